// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-channel serial peripheral interface master. The host side sees a small register-style interface: a write strobe with a data word, a read strobe with the received word, and four status flags. Writing a word fills a one-entry transmit buffer. As soon as the shifter is free, it takes that word, pulls the chip select low and clocks the frame out on MOSI. It samples MISO at the same time and puts the result in a one-entry receive buffer.

Static control inputs set the clock polarity and phase, the frame width (8 or 16 bits), the bit order and a 3-bit prescaler for the serial clock. Each input is only taken into account while the shifter is idle. If the transmit buffer is refilled during a frame, the next frame follows without releasing chip select. An enable input holds the whole block in reset while it is low.

Top module: `spi_master_core`

## Requirements
- R1: The serial clock period equals 2^(br+1) system clock cycles for every prescaler code br from 0 to 7.
- R2: While idle, sck rests at the level of cpol (0 low, 1 high), and it is back at that level when a frame ends.
- R3: Mode {cpol,cpha} 0 and 3 present data for capture on the rising sck edge, and modes 1 and 2 on the falling edge. With cpha=0 the first bit is valid before the first edge. MSB-first is the default order (lsb_first=0).
- R4: wide16=0 selects 8-bit frames that send wr_data[7:0] and return the received byte in rd_data[7:0], with rd_data[15:8] zero. wide16=1 selects 16-bit frames.
- R5: lsb_first=1 shifts bit 0 first in both directions. The received word keeps the same bit weights as the transmitted one.
- R6: A write clears txe on the next cycle. When the shifter takes the word one cycle later, txe is set again, busy rises and cs_n goes low.
- R7: A completed frame sets rxne and puts the word on rd_data. A read strobe clears rxne.
- R8: busy stays high for the whole frame and falls together with cs_n rising when no further word is waiting.
- R9: A frame that completes while rxne is still set sets ovr and leaves rd_data unchanged. A read clears ovr and rxne.
- R10: A word written while a frame is running starts a second frame right away, and cs_n stays low across both frames.
- R11: Changes of cpol, cpha, wide16, lsb_first and br during a frame do not alter that frame. They take effect once the block is idle.
- R12: With en low, busy is 0, cs_n is 1, sck sits at cpol, txe is 1, rxne is 0, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| en | input | 1 | Block enable; low holds the block in reset |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: capture on first edge, 1: on second edge |
| wide16 | input | 1 | 0: 8-bit frames, 1: 16-bit frames |
| lsb_first | input | 1 | 1: least significant bit first |
| br | input | BR_W | Prescaler code, sck = clk / 2^(br+1) |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Word to transmit, right-aligned |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | DATA_W | Last received word |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer holds unread data |
| busy | output | 1 | Frame in progress |
| ovr | output | 1 | A received frame was dropped |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default parameters: 16-bit data path, 8-bit narrow frames and a 3-bit prescaler. It covers all four modes, both widths and both bit orders. It also steps through all eight prescaler codes, which puts every sck divisor from 2 to 256 within reach. MISO is looped back from MOSI through a selectable inverter, so the expected receive word is an XOR of the sent word. This makes bit-order or capture-edge faults show up as data mismatches. The narrow-frame setting exposes the right-alignment and the zeroed upper byte.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic wide;
      logic lsb;
   } spi_mode_t;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } spi_st_e;

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
   parameter int BR_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            clr,
   input  logic [BR_W-1:0] br,
   output logic            tick
);
   localparam int CNT_W = (1 << BR_W) - 1;

   generate
      if (BR_W < 1 || BR_W > 4) begin : g_bad_br
         $error("spi_sck_div: BR_W must be 1..4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   half;
   logic [CNT_W:0]   half_m1;

   assign half    = (CNT_W+1)'(1) << br;
   assign half_m1 = half - (CNT_W+1)'(1);
   assign tick    = run && (cnt == half_m1[CNT_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !run || tick) cnt <= '0;
      else                               cnt <= cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ({1'b0, cnt} < half)); // R1

endmodule

// File: rtl/spi_order_map.sv
module spi_order_map #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] d,
   input  logic              wide,
   input  logic              lsb,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0]   rev_full;
   logic [NARROW_W-1:0] rev_low;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_full
         assign rev_full[i] = d[DATA_W-1-i];
      end
      for (genvar j = 0; j < NARROW_W; j++) begin : g_low
         assign rev_low[j] = d[NARROW_W-1-j];
      end
   endgenerate

   always_comb begin
      if (!lsb)     q = d;
      else if (wide) q = rev_full;
      else          q = {d[DATA_W-1:NARROW_W], rev_low};
   end

endmodule

// File: rtl/spi_data_regs.sv
module spi_data_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              take,
   input  logic              store,
   input  logic [DATA_W-1:0] rx_in,
   output logic [DATA_W-1:0] tx_buf,
   output logic [DATA_W-1:0] rx_buf,
   output logic              txe,
   output logic              rxne,
   output logic              ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         tx_buf <= '0;
         rx_buf <= '0;
         txe    <= 1'b1;
         rxne   <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         if (wr_en) begin
            tx_buf <= wr_data;
            txe    <= 1'b0;
         end else if (take) begin
            txe <= 1'b1;
         end
         if (store) begin
            if (rxne && !rd_en) begin
               ovr <= 1'b1;
            end else begin
               rx_buf <= rx_in;
               rxne   <= 1'b1;
               if (rd_en) ovr <= 1'b0;
            end
         end else if (rd_en) begin
            rxne <= 1'b0;
            ovr  <= 1'b0;
         end
      end
   end

   AST_WR_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_en) |=> (!txe || !en)); // R6
   AST_RD_CLEARS_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd_en && !store) |=> !rxne); // R7
   AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (en && store && rxne && !rd_en) |=> (!en || (ovr && $stable(rx_buf)))); // R9

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_mst_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int BR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  spi_mode_t         mode_in,
   input  logic [BR_W-1:0]   br_in,
   input  logic              tx_ready,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              tick,
   input  logic              miso,
   output spi_mode_t         mode_eff,
   output logic [BR_W-1:0]   br_q,
   output logic              run,
   output logic              take,
   output logic              store,
   output logic [DATA_W-1:0] rx_word,
   output logic              busy,
   output logic              cs_n,
   output logic              sck,
   output logic              mosi
);
   localparam int EW = $clog2(2*DATA_W+1);
   localparam logic [EW-1:0] LAST_W = EW'(2*DATA_W);
   localparam logic [EW-1:0] LAST_N = EW'(2*NARROW_W);

   spi_st_e           state;
   spi_mode_t         mode_q;
   logic [EW-1:0]     idx;
   logic [EW-1:0]     last;
   logic [DATA_W-1:0] sreg;
   logic [DATA_W-1:0] rreg;
   logic [DATA_W-1:0] aligned;
   logic              sck_q;
   logic              cs_q;
   logic              hold;
   logic              at_end;

   assign mode_eff = (state == ST_IDLE) ? mode_in : mode_q;
   assign last     = mode_q.wide ? LAST_W : LAST_N;
   assign at_end   = (idx == last);
   assign aligned  = mode_eff.wide ? tx_word
                                   : {tx_word[NARROW_W-1:0], {(DATA_W-NARROW_W){1'b0}}};
   assign run      = (state == ST_SHIFT);
   assign take     = en && tx_ready && ((state == ST_IDLE) || (run && tick && at_end));
   assign store    = en && run && tick && at_end;
   assign rx_word  = rreg;
   assign busy     = run;
   assign cs_n     = cs_q;
   assign sck      = sck_q;
   assign mosi     = sreg[DATA_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= '0;
         br_q   <= '0;
         sck_q  <= 1'b0;
         cs_q   <= 1'b1;
         idx    <= '0;
         sreg   <= '0;
         rreg   <= '0;
         hold   <= 1'b0;
      end else if (!en) begin
         state  <= ST_IDLE;
         mode_q <= mode_in;
         br_q   <= br_in;
         sck_q  <= mode_in.cpol;
         cs_q   <= 1'b1;
         idx    <= '0;
         hold   <= 1'b0;
      end else if (state == ST_IDLE) begin
         mode_q <= mode_in;
         br_q   <= br_in;
         sck_q  <= mode_in.cpol;
         if (tx_ready) begin
            state <= ST_SHIFT;
            cs_q  <= 1'b0;
            idx   <= '0;
            sreg  <= aligned;
            rreg  <= '0;
            hold  <= mode_in.cpha;
         end
      end else if (tick) begin
         if (at_end) begin
            if (tx_ready) begin
               idx  <= '0;
               sreg <= aligned;
               rreg <= '0;
               hold <= mode_q.cpha;
            end else begin
               state <= ST_IDLE;
               cs_q  <= 1'b1;
            end
         end else begin
            sck_q <= ~sck_q;
            idx   <= idx + 1'b1;
            if (idx[0] == mode_q.cpha) rreg <= {rreg[DATA_W-2:0], miso};
            else if (hold)             hold <= 1'b0;
            else                       sreg <= {sreg[DATA_W-2:0], 1'b0};
         end
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mode_q) && $stable(br_q))); // R11
   AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= last)); // R4
   AST_SCK_REST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      store |-> (sck_q == mode_q.cpol)); // R2
   AST_CS_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_q); // R8

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
   import spi_mst_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int BR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              wide16,
   input  logic              lsb_first,
   input  logic [BR_W-1:0]   br,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              txe,
   output logic              rxne,
   output logic              busy,
   output logic              ovr,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   generate
      if (NARROW_W < 2 || NARROW_W >= DATA_W) begin : g_bad_w
         $error("spi_master_core: need 2 <= NARROW_W < DATA_W");
      end
   endgenerate

   spi_mode_t         mode_in;
   spi_mode_t         mode_eff;
   logic [BR_W-1:0]   br_q;
   logic [DATA_W-1:0] tx_buf;
   logic [DATA_W-1:0] tx_word;
   logic [DATA_W-1:0] rx_raw;
   logic [DATA_W-1:0] rx_word;
   logic              take;
   logic              store;
   logic              tick;
   logic              run;

   assign mode_in = '{cpol: cpol, cpha: cpha, wide: wide16, lsb: lsb_first};

   spi_data_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .en(en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .take(take), .store(store), .rx_in(rx_word),
      .tx_buf(tx_buf), .rx_buf(rd_data),
      .txe(txe), .rxne(rxne), .ovr(ovr)
   );

   spi_order_map #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_tx_map (
      .d(tx_buf), .wide(mode_eff.wide), .lsb(mode_eff.lsb), .q(tx_word)
   );

   spi_order_map #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_rx_map (
      .d(rx_raw), .wide(mode_eff.wide), .lsb(mode_eff.lsb), .q(rx_word)
   );

   spi_sck_div #(.BR_W(BR_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(take), .br(br_q), .tick(tick)
   );

   spi_shift_engine #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .BR_W(BR_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en),
      .mode_in(mode_in), .br_in(br),
      .tx_ready(!txe), .tx_word(tx_word), .tick(tick), .miso(miso),
      .mode_eff(mode_eff), .br_q(br_q), .run(run),
      .take(take), .store(store), .rx_word(rx_raw),
      .busy(busy), .cs_n(cs_n), .sck(sck), .mosi(mosi)
   );

endmodule

// File: tb/test_spi_master_core.sv
`timescale 1ns/1ps
module test_spi_master_core;
   localparam int DW = 16;
   localparam int NW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic cpol = 1'b0, cpha = 1'b0, wide16 = 1'b0, lsb_first = 1'b0;
   logic [2:0] br = 3'd0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic txe, rxne, busy, ovr, sck, mosi, miso, cs_n;
   logic miso_inv = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   assign miso = mosi ^ miso_inv;

   always #10 clk = ~clk;

   spi_master_core i_spi_master_core (
      .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
      .wide16(wide16), .lsb_first(lsb_first), .br(br),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .txe(txe), .rxne(rxne), .busy(busy), .ovr(ovr),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic setup(input int mode, input bit wd, input bit lsb, input int brv);
      @(negedge clk);
      cpol = mode[1]; cpha = mode[0]; wide16 = wd; lsb_first = lsb; br = brv[2:0];
      @(negedge clk);
      @(negedge clk);
      chk("R2 idle sck", {31'd0, sck}, {31'd0, cpol});
   endtask

   task automatic frame(input int mode, input bit wd, input bit lsb, input int brv,
                        input logic [DW-1:0] data, input bit inv, input bit do_read);
      int nb = wd ? DW : NW;
      logic [DW-1:0] col = '0;
      logic [DW-1:0] mask = wd ? 16'hFFFF : 16'h00FF;
      logic [DW-1:0] exp_rx;
      time t0 = 0, t1 = 0;
      bit cap_rise = (mode == 0) || (mode == 3);
      setup(mode, wd, lsb, brv);
      miso_inv = inv;
      exp_rx = (data & mask) ^ (inv ? mask : 16'h0000);
      fork
         begin
            for (int i = 0; i < nb; i++) begin
               if (cap_rise) @(posedge sck); else @(negedge sck);
               if (i == 0) t0 = $time;
               if (i == 1) t1 = $time;
               col[lsb ? i : nb-1-i] = mosi;
            end
         end
         begin
            wr_en = 1'b1; wr_data = data;
            @(negedge clk);
            wr_en = 1'b0;
            chk("R6 txe cleared", {31'd0, txe}, 32'd0);
            @(negedge clk);
            chk("R6 txe after take", {31'd0, txe}, 32'd1);
            chk("R8 busy raised", {31'd0, busy}, 32'd1);
            chk("R6 cs_n low", {31'd0, cs_n}, 32'd0);
         end
      join
      while (busy) @(negedge clk);
      if (lsb) chk("R5 mosi word", {16'd0, col}, {16'd0, data & mask});
      else     chk("R3 mosi word", {16'd0, col}, {16'd0, data & mask});
      chk("R1 sck period", 32'(t1 - t0), 32'((2 ** (brv + 1)) * 20));
      chk("R8 cs_n released", {31'd0, cs_n}, 32'd1);
      chk("R7 rxne set", {31'd0, rxne}, 32'd1);
      if (do_read) begin
         if (wd) chk("R4 rx word 16", {16'd0, rd_data}, {16'd0, exp_rx});
         else    chk("R4 rx word 8", {16'd0, rd_data}, {16'd0, exp_rx});
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         chk("R7 rxne cleared", {31'd0, rxne}, 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; en = 1'b1;
      @(negedge clk);
      chk("R6 reset txe", {31'd0, txe}, 32'd1);
      chk("R7 reset rxne", {31'd0, rxne}, 32'd0);
      chk("R8 reset busy", {31'd0, busy}, 32'd0);
      chk("R9 reset ovr", {31'd0, ovr}, 32'd0);
      chk("R8 reset cs_n", {31'd0, cs_n}, 32'd1);
      chk("R2 reset sck", {31'd0, sck}, 32'd0);

      // R3 R4 R5: all modes, widths and orders
      for (int k = 0; k < 16; k++) begin
         frame(k % 4, k[2], k[3], k % 4, 16'hA5C3 ^ 16'(k * 16'h1357), k[0], 1'b1);
      end

      // R1: every prescaler code
      for (int b = 0; b < 8; b++) begin
         frame(0, 1'b0, 1'b0, b, 16'h3C00 | 16'(b * 16'h11), 1'b0, 1'b1);
      end

      // R9: overrun keeps the first word
      frame(1, 1'b0, 1'b0, 0, 16'h005A, 1'b0, 1'b0);
      frame(1, 1'b0, 1'b0, 0, 16'h00C7, 1'b0, 1'b0);
      chk("R9 ovr set", {31'd0, ovr}, 32'd1);
      chk("R9 old data kept", {16'd0, rd_data}, 32'h005A);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9 ovr cleared", {31'd0, ovr}, 32'd0);
      chk("R9 rxne cleared", {31'd0, rxne}, 32'd0);

      // R10: back-to-back frames keep chip select low
      begin
         int hi = 0;
         bit got = 1'b0;
         setup(1, 1'b0, 1'b0, 0);
         miso_inv = 1'b0;
         wr_en = 1'b1; wr_data = 16'h0096;
         @(negedge clk);
         wr_en = 1'b0;
         @(negedge clk);
         wr_en = 1'b1; wr_data = 16'h0069;
         @(negedge clk);
         wr_en = 1'b0;
         chk("R10 second word pending", {31'd0, txe}, 32'd0);
         while (busy) begin
            @(negedge clk);
            rd_en = 1'b0;
            if (cs_n) hi++;
            if (rxne && !got) begin
               chk("R10 first word", {16'd0, rd_data}, 32'h0096);
               rd_en = 1'b1;
               got = 1'b1;
            end
         end
         rd_en = 1'b0;
         chk("R10 cs_n gaps", 32'(hi), 32'd1);
         chk("R10 second word", {16'd0, rd_data}, 32'h0069);
         chk("R10 no overrun", {31'd0, ovr}, 32'd0);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end

      // R11: config changes during a frame are deferred
      begin
         int len = 0;
         setup(0, 1'b0, 1'b0, 1);
         miso_inv = 1'b1;
         wr_en = 1'b1; wr_data = 16'h12B4;
         @(negedge clk);
         wr_en = 1'b0;
         @(negedge clk);
         cpol = 1'b1; cpha = 1'b1; wide16 = 1'b1; br = 3'd7;
         while (busy) begin
            @(negedge clk);
            len++;
         end
         chk("R11 frame length", 32'(len), 32'd34);
         chk("R11 rx word", {16'd0, rd_data}, 32'h004B);
         @(negedge clk);
         chk("R11 new idle level", {31'd0, sck}, 32'd1);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end

      // R12: enable low aborts and holds reset
      begin
         setup(2, 1'b1, 1'b0, 7);
         wr_en = 1'b1; wr_data = 16'hBEEF;
         @(negedge clk);
         wr_en = 1'b0;
         repeat (50) @(negedge clk);
         chk("R12 busy before disable", {31'd0, busy}, 32'd1);
         en = 1'b0;
         @(negedge clk);
         chk("R12 busy", {31'd0, busy}, 32'd0);
         chk("R12 cs_n", {31'd0, cs_n}, 32'd1);
         chk("R12 sck idle", {31'd0, sck}, 32'd1);
         chk("R12 txe", {31'd0, txe}, 32'd1);
         chk("R12 rxne", {31'd0, rxne}, 32'd0);
         wr_en = 1'b1; wr_data = 16'h1111;
         @(negedge clk);
         wr_en = 1'b0;
         @(negedge clk);
         chk("R12 write ignored", {31'd0, txe}, 32'd1);
         chk("R12 still idle", {31'd0, busy}, 32'd0);
         en = 1'b1;
         @(negedge clk);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule